// File: doc/BRIEF.md
# ECC Error Status Register Bank

This block gathers error events from a memory controller's ECC decoder. It keeps them in a small bank of registers that software reads and writes through a simple port. On any access the decoder raises a one-cycle pulse: one line marks a correctable error and another marks an uncorrectable one. Each pulse comes with the failing word address, the data word and the stored check bits.

The bank holds two sticky status flags, which software clears by writing ones. It also holds a per-class interrupt enable and a saturating count of correctable errors. Each error class has capture registers that keep the details of the first failure until software acknowledges it. The interrupt output is asserted while any enabled status flag is set. The read data is combinational from the addressed register, so a read returns the state present after the last clock edge.

Top module: `ecc_stat_regs`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Status register at index 0 has bit 0 for correctable and bit 1 for uncorrectable errors. An error pulse sets its bit on the next edge. Writing a 1 to a bit clears it, and writing a 0 to a bit leaves it unchanged.
- R3: When an error pulse and a clearing write to the same status bit fall in one cycle, the bit stays set.
- R4: The interrupt-enable register at index 1 is read/write in bits [1:0], with the same bit order as the status register. Its upper bits read zero.
- R5: `irq` is high exactly when some status bit and its enable bit are both set.
- R6: The correctable counter at index 2 is CNT_W bits wide, zero-extended on read. A write loads the low CNT_W bits of the write data, so writing all ones reads back 2^CNT_W-1 and writing zero reads back zero.
- R7: Each correctable pulse adds one to the counter, and the counter holds at 2^CNT_W-1 once it reaches that value.
- R8: A counter write in the same cycle as a correctable pulse loads the written value and drops the increment.
- R9: Index 3 holds the failing address of a correctable error. It loads only on a pulse that arrives while status bit 0 is clear.
- R10: Indexes 4, 5 and 6 hold the failing address, data and check bits of an uncorrectable error. They load only on a pulse that arrives while status bit 1 is clear.
- R11: Writes to indexes 3 to 7 have no effect on any register, and index 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_pulse | input | 1 | One-cycle correctable error event |
| ue_pulse | input | 1 | One-cycle uncorrectable error event |
| fail_addr | input | ADDR_W | Word address of the failing access |
| fail_data | input | DATA_W | Data word of the failing access |
| fail_chk | input | CHK_W | Stored check bits of the failing access |
| reg_addr | input | 3 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the indexed register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are collisions within a single cycle. One is an error pulse landing on the same edge as a clearing write to its status bit. Another is a correctable pulse landing on the same edge as a counter load. A third is a second failure arriving while the first is still held. Directed steps set up each collision on purpose. The bench also builds the counter only four bits wide, so that random pulses mixed with random register writes reach saturation and the edges around it many times.

// File: rtl/ecc_stat_pkg.sv
package ecc_stat_pkg;

    localparam int REG_IDX_W = 3;
    localparam int BUS_W     = 32;
    localparam int NUM_CLASS = 2;
    localparam int CLS_CE    = 0;
    localparam int CLS_UE    = 1;

    typedef enum logic [REG_IDX_W-1:0] {
        RG_STATUS = 3'd0,
        RG_IRQEN  = 3'd1,
        RG_CECNT  = 3'd2,
        RG_CEADDR = 3'd3,
        RG_UEADDR = 3'd4,
        RG_UEDATA = 3'd5,
        RG_UECHK  = 3'd6,
        RG_RSVD   = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/ecc_stat_flags.sv
module ecc_stat_flags #(
    parameter int NCLS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLS-1:0] evt,
    input  logic            st_wr,
    input  logic            en_wr,
    input  logic [NCLS-1:0] wbits,
    output logic [NCLS-1:0] st_q,
    output logic [NCLS-1:0] en_q,
    output logic            irq
);

    typedef struct packed {
        logic [NCLS-1:0] st;
        logic [NCLS-1:0] en;
    } flag_state_t;

    flag_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NCLS; i++) begin
            if (st_wr && wbits[i]) begin
                s_d.st[i] = 1'b0;
            end
            if (evt[i]) begin
                s_d.st[i] = 1'b1;
            end
        end
        if (en_wr) begin
            s_d.en = wbits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign st_q = s_q.st;
    assign en_q = s_q.en;
    assign irq  = |(s_q.st & s_q.en);

    // R5
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);

    for (genvar g = 0; g < NCLS; g++) begin : g_cls
        // R2
        status_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> st_q[g]);
        // R3
        collide_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[g] && st_wr && wbits[g]) |=> st_q[g]);
        // R2
        w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_wr && wbits[g] && !evt[g]) |=> !st_q[g]);
        // R2
        zero_write_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[g] && !(st_wr && wbits[g])) |=> st_q[g]);
    end

endmodule

// File: rtl/ecc_stat_sat_counter.sv
module ecc_stat_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt_q
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ld) begin
            s_d.cnt = ld_val;
        end else if (inc && (s_q.cnt != CNT_MAX)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_q = s_q.cnt;

    // R7
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R8
    cnt_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt_q == $past(ld_val)));
    // R7
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !ld) |=> $stable(cnt_q));

endmodule

// File: rtl/ecc_stat_capture.sv
module ecc_stat_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hit,
    input  logic         armed,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] val;
    } cap_state_t;

    cap_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hit && armed) begin
            s_d.val = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign q = s_q.val;

    // R9 R10
    cap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && armed) |=> (q == $past(din)));
    // R9 R10
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && armed) |=> $stable(q));

endmodule

// File: rtl/ecc_stat_regs.sv
module ecc_stat_regs
    import ecc_stat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CHK_W  = 7,
    parameter int CNT_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce_pulse,
    input  logic                 ue_pulse,
    input  logic [ADDR_W-1:0]    fail_addr,
    input  logic [DATA_W-1:0]    fail_data,
    input  logic [CHK_W-1:0]     fail_chk,
    input  logic [REG_IDX_W-1:0] reg_addr,
    input  logic                 reg_wr,
    input  logic [BUS_W-1:0]     reg_wdata,
    output logic [BUS_W-1:0]     reg_rdata,
    output logic                 irq
);

    logic [NUM_CLASS-1:0] evt;
    logic [NUM_CLASS-1:0] st_q;
    logic [NUM_CLASS-1:0] en_q;
    logic                 wr_status;
    logic                 wr_irqen;
    logic                 wr_cnt;
    logic [CNT_W-1:0]     cnt_q;
    logic [ADDR_W-1:0]    ce_addr_q;
    logic [ADDR_W-1:0]    ue_addr_q;
    logic [DATA_W-1:0]    ue_data_q;
    logic [CHK_W-1:0]     ue_chk_q;
    logic                 wdata_unused;
    reg_sel_e             sel;

    assign sel          = reg_sel_e'(reg_addr);
    assign wr_status    = reg_wr && (sel == RG_STATUS);
    assign wr_irqen     = reg_wr && (sel == RG_IRQEN);
    assign wr_cnt       = reg_wr && (sel == RG_CECNT);
    assign wdata_unused = ^reg_wdata;

    assign evt[CLS_CE] = ce_pulse;
    assign evt[CLS_UE] = ue_pulse;

    ecc_stat_flags #(.NCLS(NUM_CLASS)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .st_wr (wr_status),
        .en_wr (wr_irqen),
        .wbits (reg_wdata[NUM_CLASS-1:0]),
        .st_q  (st_q),
        .en_q  (en_q),
        .irq   (irq)
    );

    ecc_stat_sat_counter #(.W(CNT_W)) u_cecnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (ce_pulse),
        .ld     (wr_cnt),
        .ld_val (reg_wdata[CNT_W-1:0]),
        .cnt_q  (cnt_q)
    );

    ecc_stat_capture #(.W(ADDR_W)) u_ce_addr (
        .clk (clk), .rst_n (rst_n), .hit (ce_pulse), .armed (!st_q[CLS_CE]),
        .din (fail_addr), .q (ce_addr_q)
    );

    ecc_stat_capture #(.W(ADDR_W)) u_ue_addr (
        .clk (clk), .rst_n (rst_n), .hit (ue_pulse), .armed (!st_q[CLS_UE]),
        .din (fail_addr), .q (ue_addr_q)
    );

    ecc_stat_capture #(.W(DATA_W)) u_ue_data (
        .clk (clk), .rst_n (rst_n), .hit (ue_pulse), .armed (!st_q[CLS_UE]),
        .din (fail_data), .q (ue_data_q)
    );

    ecc_stat_capture #(.W(CHK_W)) u_ue_chk (
        .clk (clk), .rst_n (rst_n), .hit (ue_pulse), .armed (!st_q[CLS_UE]),
        .din (fail_chk), .q (ue_chk_q)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            RG_STATUS: reg_rdata = BUS_W'(st_q);
            RG_IRQEN:  reg_rdata = BUS_W'(en_q);
            RG_CECNT:  reg_rdata = BUS_W'(cnt_q);
            RG_CEADDR: reg_rdata = BUS_W'(ce_addr_q);
            RG_UEADDR: reg_rdata = BUS_W'(ue_addr_q);
            RG_UEDATA: reg_rdata = BUS_W'(ue_data_q);
            RG_UECHK:  reg_rdata = BUS_W'(ue_chk_q);
            default:   reg_rdata = '0;
        endcase
    end

    // R11
    rsvd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == RG_RSVD) |-> (reg_rdata == '0));
    // R5
    irq_rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ((st_q & en_q) != '0));
    // R4
    irqen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_irqen |=> $stable(en_q));

endmodule

// File: tb/ecc_stat_regs_tb.sv
`timescale 1ns/1ps
module ecc_stat_regs_tb;

    localparam int CW = 4;
    localparam logic [31:0] CMAX = (32'd1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_pulse = 1'b0, ue_pulse = 1'b0;
    logic [31:0] fail_addr = '0, fail_data = '0;
    logic [6:0]  fail_chk = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // reference model state
    logic [1:0]  m_st = '0, m_en = '0;
    logic [31:0] m_cnt = '0, m_cea = '0, m_uea = '0, m_ued = '0;
    logic [6:0]  m_uec = '0;

    always #4 clk = ~clk;

    ecc_stat_regs #(.ADDR_W(32), .DATA_W(32), .CHK_W(7), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_pulse(ce_pulse), .ue_pulse(ue_pulse),
        .fail_addr(fail_addr), .fail_data(fail_data), .fail_chk(fail_chk),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_reg(input int idx);
        case (idx)
            0: return {30'd0, m_st};
            1: return {30'd0, m_en};
            2: return m_cnt;
            3: return m_cea;
            4: return m_uea;
            5: return m_ued;
            6: return {25'd0, m_uec};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input int idx);
        case (idx)
            0: return "R2";
            1: return "R4";
            2: return "R7";
            3: return "R9";
            4, 5, 6: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        ce_pulse = 0; ue_pulse = 0; reg_wr = 0;
        for (int i = 0; i < 8; i++) begin
            reg_addr = 3'(i);
            #0.4;
            chk((tag != "") ? tag : tag_of(i), reg_rdata, exp_reg(i));
        end
        chk((tag != "") ? tag : "R5", {31'd0, irq}, {31'd0, |(m_st & m_en)});
    endtask

    task automatic step(input logic ce, input logic ue, input logic [31:0] a,
                        input logic [31:0] d, input logic [6:0] c, input logic wr,
                        input logic [2:0] wa, input logic [31:0] wd);
        logic [1:0] nst;
        @(negedge clk);
        ce_pulse = ce; ue_pulse = ue; fail_addr = a; fail_data = d; fail_chk = c;
        reg_wr = wr; reg_addr = wa; reg_wdata = wd;
        @(posedge clk);
        nst = m_st;
        if (wr && wa == 3'd0) nst = nst & ~wd[1:0];
        if (ce) nst[0] = 1'b1;
        if (ue) nst[1] = 1'b1;
        if (ce && !m_st[0]) m_cea = a;
        if (ue && !m_st[1]) begin m_uea = a; m_ued = d; m_uec = c; end
        if (wr && wa == 3'd2) m_cnt = wd & CMAX;
        else if (ce && m_cnt != CMAX) m_cnt = m_cnt + 1;
        if (wr && wa == 3'd1) m_en = wd[1:0];
        m_st = nst;
    endtask

    task automatic wr_reg(input logic [2:0] wa, input logic [31:0] wd);
        step(0, 0, 0, 0, 0, 1, wa, wd);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check_all("R1");

        // R4 enable register read/write, upper bits zero
        wr_reg(3'd1, 32'hFFFF_FFFF); check_all("R4");
        wr_reg(3'd1, 32'h0);         check_all("R4");

        // R2 correctable pulse sets status, R5 no irq while disabled
        step(1, 0, 32'h0000_1234, 32'hAA, 7'h11, 0, 0, 0); check_all("R2");
        wr_reg(3'd1, 32'h1); check_all("R5");
        // R9 second failure does not overwrite
        step(1, 0, 32'h0000_5678, 32'hBB, 7'h22, 0, 0, 0); check_all("R9");
        // R2 writing zero keeps the bit
        wr_reg(3'd0, 32'h0); check_all("R2");
        // R3 pulse and clear in one cycle keep the bit
        step(1, 0, 32'h0000_9ABC, 0, 0, 1, 3'd0, 32'h1); check_all("R3");
        wr_reg(3'd0, 32'h1); check_all("R2");
        // R9 rearmed capture
        step(1, 0, 32'h0000_DEF0, 0, 0, 0, 0, 0); check_all("R9");

        // R10 uncorrectable first-failure capture
        step(0, 1, 32'h0BAD_0001, 32'hCAFE_F00D, 7'h5A, 0, 0, 0); check_all("R10");
        step(0, 1, 32'h0BAD_0002, 32'h1234_5678, 7'h25, 0, 0, 0); check_all("R10");
        wr_reg(3'd1, 32'h2); check_all("R5");
        wr_reg(3'd0, 32'h3); check_all("R2");

        // R6 counter load masking
        wr_reg(3'd2, 32'hFFFF_FFFF); check_all("R6");
        wr_reg(3'd2, 32'h0);         check_all("R6");
        // R7 saturation
        wr_reg(3'd2, CMAX - 1);
        step(1, 0, 32'h10, 0, 0, 0, 0, 0); check_all("R7");
        step(1, 0, 32'h14, 0, 0, 0, 0, 0); check_all("R7");
        // R8 load wins over increment
        step(1, 0, 32'h18, 0, 0, 1, 3'd2, 32'h5); check_all("R8");

        // R11 writes to capture and reserved indexes ignored
        for (int k = 3; k < 8; k++) wr_reg(3'(k), 32'hFFFF_FFFF);
        check_all("R11");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic wr;
            logic [2:0] wa;
            logic [31:0] wd;
            wr = ($urandom % 5) == 0;
            wa = 3'($urandom % 8);
            wd = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom;
            step(($urandom % 3) == 0, ($urandom % 7) == 0, $urandom, $urandom,
                 7'($urandom), wr, wa, wd);
            if (n % 16 == 15) check_all("");
        end
        check_all("");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule